// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Comparator

This block holds four hardware breakpoint triggers for a processor core and decides, for every memory or fetch access the core presents, whether a trigger fires and which one. Each trigger keeps a control word and a compare value, both loaded through a small write port. The control word enables the trigger per operation type and per privilege level, chooses whether the address or the data operand is compared, selects one of six compare modes, and can link the trigger to its successor.

On every cycle with a valid strobe, the core drives the operation type, the privilege level, the address, the data operand, a debug-mode flag and a 32-bit width flag. Triggers are scanned from index 0 upward, and the lowest-indexed trigger that reports a hit wins. A linked group of triggers reports a single hit, carried by its last member, and only when every member matches. The result is registered and appears one cycle after the access.

Top module: `dbg_trig_match`

## Requirements
- R1: After reset every control word and compare value is zero, so no trigger is enabled; `hit` and `hit_idx` read 0, and an access with no prior writes gives no hit.
- R2: When `cfg_we` is high, `cfg_sel`=0 loads the control word of trigger `cfg_idx` and `cfg_sel`=1 loads its compare value. The new value applies to accesses from the following cycle. An access in the same cycle as the write sees the old value. Control bit layout: [0] execute enable, [1] store enable, [2] load enable, [3] U enable, [4] S enable, [5] M enable, [8:6] mode, [9] compare data instead of address, [10] chain.
- R3: `hit` and `hit_idx` update at the clock edge that samples `acc_valid`=1. When no trigger hits, `hit_idx` is 0. A cycle without `acc_valid` gives `hit`=0 on the next cycle and leaves `hit_idx` unchanged.
- R4: A trigger takes part only if the enable bit for `acc_op` is set. Encoding: 0 execute, 1 store, 2 load. Code 3 never matches.
- R5: A trigger takes part only if the enable bit for `acc_priv` is set. Encoding: 0 U, 1 S, 3 M. Code 2 never matches.
- R6: With control bit 9 set, `acc_data` is the compared value. With bit 9 clear, `acc_addr` is compared.
- R7: With `narrow` high, only the low 32 bits of the compared value are used, and the masked modes split the value at bit 16 instead of at XLEN/2.
- R8: Mode 0 matches on equality. Mode 2 matches when the value is greater than or equal to the compare value, unsigned. Mode 3 matches when the value is less than it, unsigned. Modes 6 and 7 never match.
- R9: Mode 1 counts the k trailing ones of the compare value and matches when value and compare value agree in every bit above bit k.
- R10: In modes 4 and 5, the mask is the compare value shifted right by the half width. Mode 4 matches when (value AND mask) equals (compare value AND mask). Mode 5 does the same with the value shifted down by the half width.
- R11: A trigger that matches with its chain bit set reports no hit itself. The next unchained trigger reports the hit only if it also matches. If a member of a chain fails, every later member of that chain, up to and including its first unchained trigger, is suppressed, and the scan resumes after that trigger.
- R12: When several triggers hit, `hit_idx` is the lowest index.
- R13: An access with `in_debug` high never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Trigger register write strobe |
| cfg_idx | input | 2 | Trigger selected for the write |
| cfg_sel | input | 1 | 0 writes the control word, 1 writes the compare value |
| cfg_wdata | input | 64 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_op | input | 2 | Operation type of the access |
| acc_priv | input | 2 | Privilege level of the access |
| acc_addr | input | 64 | Access address |
| acc_data | input | 64 | Access data operand |
| in_debug | input | 1 | Core is in debug mode |
| narrow | input | 1 | Core runs with 32-bit width |
| hit | output | 1 | A trigger fired on the previous access |
| hit_idx | output | 2 | Index of the trigger that fired |

## Verification
Each compare mode is driven with a value just inside and just outside its matching set. This separates off-by-one errors in the GE/LT bounds, the NAPOT bit count and the mask halves. Filter tests switch one attribute at a time (operation, privilege, reserved code, address or data source), so a wrong enable bit shows up as a missing or extra hit. Chain tests use three data and address combinations against a two-member chain followed by a single trigger. These separate a correct group hit, a suppressed first member, and resumption after a broken chain. Narrow-width accesses use values whose upper bits differ, so truncation and the 16-bit mask split can be told apart from the full-width behaviour.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_NONE  = 2'd3
  } acc_op_e;

  typedef enum logic [2:0] {
    CMP_EQ    = 3'd0,
    CMP_RANGE = 3'd1,
    CMP_GE    = 3'd2,
    CMP_LT    = 3'd3,
    CMP_MLOW  = 3'd4,
    CMP_MHIGH = 3'd5,
    CMP_RSV6  = 3'd6,
    CMP_RSV7  = 3'd7
  } cmp_mode_e;

  localparam int CTRL_W = 11;

  typedef struct packed {
    logic      chain;
    logic      use_data;
    cmp_mode_e mode;
    logic      m_en;
    logic      s_en;
    logic      u_en;
    logic      load_en;
    logic      store_en;
    logic      exec_en;
  } trig_ctrl_t;

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 64,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             sel,
  input  logic [XLEN-1:0]  wdata,
  output trig_ctrl_t       ctrl_o [NUM_TRIG],
  output logic [XLEN-1:0]  cmp_o  [NUM_TRIG]
);

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    trig_ctrl_t      ctrl_q, ctrl_d;
    logic [XLEN-1:0] cmp_q, cmp_d;
    logic            wr_en;

    assign wr_en = we && (idx == IDX_W'(t));

    always_comb begin
      ctrl_d = ctrl_q;
      cmp_d  = cmp_q;
      if (sel) cmp_d  = wdata;
      else     ctrl_d = trig_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        cmp_q  <= '0;
      end else if (wr_en) begin
        ctrl_q <= ctrl_d;
        cmp_q  <= cmp_d;
      end
    end

    assign ctrl_o[t] = ctrl_q;
    assign cmp_o[t]  = cmp_q;
  end

endmodule

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  trig_ctrl_t      ctrl,
  input  logic [XLEN-1:0] cmp_val,
  input  logic [1:0]      op,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] data,
  input  logic            narrow,
  output logic            match_o
);

  localparam int          WIDE_HALF   = XLEN / 2;
  localparam int          NARROW_HALF = 16;
  localparam int          SH_W        = $clog2(XLEN) + 1;

  logic            op_ok, priv_ok;
  logic [XLEN-1:0] value;
  logic [SH_W-1:0] half_sh;
  logic [XLEN-1:0] tail_ones, range_mask, half_mask;
  logic            cmp_ok;

  always_comb begin
    unique case (acc_op_e'(op))
      OP_EXEC:  op_ok = ctrl.exec_en;
      OP_STORE: op_ok = ctrl.store_en;
      OP_LOAD:  op_ok = ctrl.load_en;
      default:  op_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (priv)
      2'd0:    priv_ok = ctrl.u_en;
      2'd1:    priv_ok = ctrl.s_en;
      2'd3:    priv_ok = ctrl.m_en;
      default: priv_ok = 1'b0;
    endcase
  end

  always_comb begin
    value = ctrl.use_data ? data : addr;
    if (narrow) value = {{(XLEN-32){1'b0}}, value[31:0]};
  end

  assign half_sh    = narrow ? SH_W'(NARROW_HALF) : SH_W'(WIDE_HALF);
  assign tail_ones  = cmp_val & ~(cmp_val + XLEN'(1));
  assign range_mask = ~{tail_ones[XLEN-2:0], 1'b1};
  assign half_mask  = cmp_val >> half_sh;

  always_comb begin
    unique case (ctrl.mode)
      CMP_EQ:    cmp_ok = (value == cmp_val);
      CMP_RANGE: cmp_ok = ((value & range_mask) == (cmp_val & range_mask));
      CMP_GE:    cmp_ok = (value >= cmp_val);
      CMP_LT:    cmp_ok = (value < cmp_val);
      CMP_MLOW:  cmp_ok = ((value & half_mask) == (cmp_val & half_mask));
      CMP_MHIGH: cmp_ok = (((value >> half_sh) & half_mask) == (cmp_val & half_mask));
      default:   cmp_ok = 1'b0;
    endcase
  end

  assign match_o = op_ok && priv_ok && cmp_ok;

endmodule

// File: rtl/dbg_trig_resolve.sv
module dbg_trig_resolve #(
  parameter int NUM_TRIG = 4,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_TRIG-1:0] match,
  input  logic [NUM_TRIG-1:0] chain,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);

  always_comb begin
    logic chain_ok;
    chain_ok = 1'b1;
    found_o  = 1'b0;
    idx_o    = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (!chain_ok) begin
        if (!chain[i]) chain_ok = 1'b1;
      end else if (!match[i]) begin
        if (chain[i]) chain_ok = 1'b0;
      end else if (!chain[i] && !found_o) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 64,
  localparam int IDX_W   = $clog2(NUM_TRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_sel,
  input  logic [XLEN-1:0]  cfg_wdata,
  input  logic             acc_valid,
  input  logic [1:0]       acc_op,
  input  logic [1:0]       acc_priv,
  input  logic [XLEN-1:0]  acc_addr,
  input  logic [XLEN-1:0]  acc_data,
  input  logic             in_debug,
  input  logic             narrow,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);

  trig_ctrl_t          ctrl   [NUM_TRIG];
  logic [XLEN-1:0]     cmpv   [NUM_TRIG];
  logic [NUM_TRIG-1:0] match_vec;
  logic [NUM_TRIG-1:0] chain_vec;
  logic                found;
  logic [IDX_W-1:0]    win_idx;
  logic                hit_d, hit_q;
  logic [IDX_W-1:0]    idx_d, idx_q;

  dbg_trig_regs #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .IDX_W(IDX_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .ctrl_o (ctrl),
    .cmp_o  (cmpv)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_cmp
    dbg_trig_cmp #(.XLEN(XLEN)) cmp_i (
      .ctrl    (ctrl[t]),
      .cmp_val (cmpv[t]),
      .op      (acc_op),
      .priv    (acc_priv),
      .addr    (acc_addr),
      .data    (acc_data),
      .narrow  (narrow),
      .match_o (match_vec[t])
    );
    assign chain_vec[t] = ctrl[t].chain;
  end

  dbg_trig_resolve #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) resolve_i (
    .match   (match_vec),
    .chain   (chain_vec),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_comb begin
    hit_d = acc_valid && found && !in_debug;
    idx_d = hit_d ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_d;
      if (acc_valid) idx_q <= idx_d;
    end
  end

  assign hit     = hit_q;
  assign hit_idx = idx_q;

endmodule

// File: rtl/dbg_trig_match_chk.sv
module dbg_trig_match_chk #(
  parameter int NUM_TRIG = 4,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic                acc_valid,
  input logic                in_debug,
  input logic                hit,
  input logic [IDX_W-1:0]    hit_idx,
  input logic [NUM_TRIG-1:0] chain_bits
);

  p_debug_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_debug) |=> !hit);

  p_idle_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit);

  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(hit_idx));

  p_chain_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !cfg_we) |=> (!hit || !chain_bits[hit_idx]));

endmodule

bind dbg_trig_match dbg_trig_match_chk #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .acc_valid  (acc_valid),
  .in_debug   (in_debug),
  .hit        (hit),
  .hit_idx    (hit_idx),
  .chain_bits (chain_vec)
);

// File: tb/dbg_trig_match_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_match_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [1:0]  cfg_idx;
  logic [63:0] cfg_wdata;
  logic        acc_valid;
  logic [1:0]  acc_op, acc_priv;
  logic [63:0] acc_addr, acc_data;
  logic        in_debug, narrow;
  logic        hit;
  logic [1:0]  hit_idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dbg_trig_match dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_op(acc_op), .acc_priv(acc_priv),
    .acc_addr(acc_addr), .acc_data(acc_data), .in_debug(in_debug), .narrow(narrow),
    .hit(hit), .hit_idx(hit_idx)
  );

  function automatic logic [63:0] mk(bit ex, bit st, bit ld, bit u, bit s, bit m,
                                     logic [2:0] mode, bit dsel, bit ch);
    return {53'd0, ch, dsel, mode, m, s, u, ld, st, ex};
  endfunction

  task automatic expect_out(input logic eh, input logic [1:0] ei, input string tag);
    n_chk++;
    if (hit !== eh || hit_idx !== ei) begin
      n_fail++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, hit, hit_idx, eh, ei);
    end
  endtask

  task automatic wr(input int t, input bit sel, input logic [63:0] v);
    cfg_we = 1'b1; cfg_idx = 2'(t); cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int t = 0; t < 4; t++) begin
      wr(t, 1'b0, 64'd0);
      wr(t, 1'b1, 64'd0);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [1:0] pv, input logic [63:0] a,
                        input logic [63:0] d, input bit dbg, input bit nar);
    acc_valid = 1'b1; acc_op = op; acc_priv = pv; acc_addr = a; acc_data = d;
    in_debug = dbg; narrow = nar;
    @(negedge clk);
    acc_valid = 1'b0; in_debug = 1'b0; narrow = 1'b0;
  endtask

  task automatic t_reset();
    expect_out(1'b0, 2'd0, "R1 reset outputs");
    access(2'd0, 2'd3, 64'd0, 64'd0, 0, 0);
    expect_out(1'b0, 2'd0, "R1 access with cleared triggers");
  endtask

  task automatic t_compare();
    clear_all();
    wr(0, 1, 64'h1000); wr(0, 0, mk(1,0,0,0,0,1, 3'd0, 0, 0));
    access(2'd0, 2'd3, 64'h1000, 0, 0, 0); expect_out(1, 2'd0, "R8 EQ equal");
    access(2'd0, 2'd3, 64'h1004, 0, 0, 0); expect_out(0, 2'd0, "R8 EQ differ");
    wr(0, 0, 64'd0);
    wr(1, 1, 64'h2000); wr(1, 0, mk(0,0,1,0,0,1, 3'd2, 0, 0));
    access(2'd2, 2'd3, 64'h2000, 0, 0, 0); expect_out(1, 2'd1, "R8 GE at bound");
    access(2'd2, 2'd3, 64'h1FFF, 0, 0, 0); expect_out(0, 2'd0, "R8 GE below");
    wr(2, 1, 64'h100); wr(2, 0, mk(0,1,0,0,0,1, 3'd3, 0, 0));
    access(2'd1, 2'd3, 64'hFF, 0, 0, 0);  expect_out(1, 2'd2, "R8 LT below");
    access(2'd1, 2'd3, 64'h100, 0, 0, 0); expect_out(0, 2'd0, "R8 LT at bound");
    wr(2, 0, mk(0,1,0,0,0,1, 3'd6, 0, 0));
    access(2'd1, 2'd3, 64'hFF, 0, 0, 0);  expect_out(0, 2'd0, "R8 reserved mode");
  endtask

  task automatic t_range();
    clear_all();
    wr(0, 1, 64'h1000_0007); wr(0, 0, mk(1,0,0,0,0,1, 3'd1, 0, 0));
    access(0, 3, 64'h1000_000F, 0, 0, 0); expect_out(1, 0, "R9 range top");
    access(0, 3, 64'h1000_0000, 0, 0, 0); expect_out(1, 0, "R9 range base");
    access(0, 3, 64'h1000_0010, 0, 0, 0); expect_out(0, 0, "R9 range above");
  endtask

  task automatic t_mask();
    clear_all();
    wr(0, 1, 64'h0000_00FF_0000_0034); wr(0, 0, mk(1,0,0,0,0,1, 3'd4, 0, 0));
    access(0, 3, 64'h00AB_CD34, 0, 0, 0); expect_out(1, 0, "R10 mask low hit");
    access(0, 3, 64'h00AB_CD35, 0, 0, 0); expect_out(0, 0, "R10 mask low miss");
    wr(0, 0, mk(1,0,0,0,0,1, 3'd5, 0, 0));
    access(0, 3, 64'h0000_1234_0000_0000, 0, 0, 0); expect_out(1, 0, "R10 mask high hit");
    access(0, 3, 64'h0000_0035_0000_0034, 0, 0, 0); expect_out(0, 0, "R10 mask high miss");
  endtask

  task automatic t_filter();
    clear_all();
    wr(0, 1, 64'h55); wr(0, 0, mk(1,0,0,0,0,1, 3'd0, 1, 0));
    access(0, 3, 64'h55, 64'h0, 0, 0);  expect_out(0, 0, "R6 address ignored");
    access(0, 3, 64'h0, 64'h55, 0, 0);  expect_out(1, 0, "R6 data compared");
    access(2, 3, 64'h0, 64'h55, 0, 0);  expect_out(0, 0, "R4 load not enabled");
    access(3, 3, 64'h0, 64'h55, 0, 0);  expect_out(0, 0, "R4 op code 3");
    access(0, 1, 64'h0, 64'h55, 0, 0);  expect_out(0, 0, "R5 S not enabled");
    wr(0, 0, mk(1,1,0,1,1,0, 3'd0, 1, 0));
    access(1, 1, 64'h0, 64'h55, 0, 0);  expect_out(1, 0, "R4 R5 store in S");
    access(1, 0, 64'h0, 64'h55, 0, 0);  expect_out(1, 0, "R5 U enabled");
    access(1, 3, 64'h0, 64'h55, 0, 0);  expect_out(0, 0, "R5 M not enabled");
    access(1, 2, 64'h0, 64'h55, 0, 0);  expect_out(0, 0, "R5 priv code 2");
  endtask

  task automatic t_narrow();
    clear_all();
    wr(0, 1, 64'h1234); wr(0, 0, mk(1,0,0,0,0,1, 3'd0, 0, 0));
    access(0, 3, 64'hFFFF_FFFF_0000_1234, 0, 0, 0); expect_out(0, 0, "R7 wide keeps upper bits");
    access(0, 3, 64'hFFFF_FFFF_0000_1234, 0, 0, 1); expect_out(1, 0, "R7 narrow truncates");
    wr(0, 1, 64'h00FF_0034); wr(0, 0, mk(1,0,0,0,0,1, 3'd5, 0, 0));
    access(0, 3, 64'hDEAD_0000_0034_0000, 0, 0, 1); expect_out(1, 0, "R7 narrow half split hit");
    access(0, 3, 64'hDEAD_0000_0035_0000, 0, 0, 1); expect_out(0, 0, "R7 narrow half split miss");
  endtask

  task automatic t_chain();
    clear_all();
    wr(0, 1, 64'h40); wr(0, 0, mk(1,0,0,0,0,1, 3'd0, 0, 1));
    wr(1, 1, 64'h99); wr(1, 0, mk(1,0,0,0,0,1, 3'd0, 1, 0));
    wr(2, 1, 64'h41); wr(2, 0, mk(1,0,0,0,0,1, 3'd0, 0, 0));
    access(0, 3, 64'h40, 64'h99, 0, 0); expect_out(1, 1, "R11 chain complete");
    access(0, 3, 64'h40, 64'h0,  0, 0); expect_out(0, 0, "R11 chain head alone");
    access(0, 3, 64'h41, 64'h99, 0, 0); expect_out(1, 2, "R11 broken chain resumes");
  endtask

  task automatic t_priority_debug();
    clear_all();
    wr(0, 1, 64'h500); wr(0, 0, mk(1,0,0,0,0,1, 3'd0, 0, 0));
    wr(3, 1, 64'h500); wr(3, 0, mk(1,0,0,0,0,1, 3'd0, 0, 0));
    access(0, 3, 64'h500, 0, 0, 0); expect_out(1, 0, "R12 lowest index");
    access(0, 3, 64'h500, 0, 1, 0); expect_out(0, 0, "R13 debug mode");
    wr(0, 0, 64'd0);
    access(0, 3, 64'h500, 0, 0, 0); expect_out(1, 3, "R12 next index");
    @(negedge clk);                 expect_out(0, 3, "R3 idle holds index");
  endtask

  task automatic t_write_timing();
    clear_all();
    wr(0, 1, 64'h700); wr(0, 0, mk(1,0,0,0,0,1, 3'd0, 0, 0));
    cfg_we = 1; cfg_idx = 0; cfg_sel = 1; cfg_wdata = 64'h800;
    access(0, 3, 64'h700, 0, 0, 0);
    cfg_we = 0;
    expect_out(1, 0, "R2 same-cycle write sees old");
    access(0, 3, 64'h800, 0, 0, 0); expect_out(1, 0, "R2 new value applies");
    access(0, 3, 64'h700, 0, 0, 0); expect_out(0, 0, "R2 old value gone");
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_valid = 0; acc_op = 0; acc_priv = 0; acc_addr = 0; acc_data = 0;
    in_debug = 0; narrow = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_compare();
    t_range();
    t_mask();
    t_filter();
    t_narrow();
    t_chain();
    t_priority_debug();
    t_write_timing();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule